// File: doc/BRIEF.md
# SPI Serial Byte Memory Slave

This block is a mode-0 SPI slave in front of a 1024-location, 8-bit memory. A host selects it with an active-low select, clocks 8-bit commands in on SI, and then either reads a stream of bytes, writes up to one page of bytes, or reads or writes a small status byte. The serial pins are treated as asynchronous. A fast system clock oversamples them, and the block reacts to the rising and falling SCK edges it detects.

Writes are buffered in a 16-byte page and committed only when select is released. Three conditions must all hold at that point: the write-enable latch is set, the write-protect pin is high, and it has been high for the whole transaction. A commit starts a timed write window of a programmable number of system clocks. During that window the status byte shows the block as busy and only the status read command is honoured. When the window ends, the write-enable latch clears itself. After reset the block does nothing until it has seen select go from high to low.

Top module: `serial_mem_slave`

## Requirements
- R1: Data on `si` is taken on SCK rising edges and `so` changes only after SCK falling edges. Every byte travels most significant bit first, so a read returns the bytes previously written.
- R2: `so_oe` is low whenever `cs_n` is high, and high while an armed transaction is selected.
- R3: After reset, no command takes effect and `so_oe` stays low until `cs_n` has gone from high to low at least once.
- R4: The opcodes are 0x06 (set write enable), 0x04 (clear write enable), 0x05 (read status), 0x01 (write status), 0x03 (read) and 0x02 (write). In the status byte, bit 0 is busy and bit 1 is the write-enable latch.
- R5: A write or status write sent while the write-enable latch is clear changes nothing and starts no busy window.
- R6: If `wp_n` is low at any time while a write transaction is selected, nothing is committed and the latch keeps its value. Driving `wp_n` low after a commit has started does not stop that commit.
- R7: The write address is two bytes, of which only the low 10 bits are used. Write data fills a 16-byte page buffer and wraps within the page. A write whose bit count is not a multiple of 8 when select rises is discarded.
- R8: After a commit, status bit 0 reads 1 until the write window has run. While it reads 1, every opcode except read status is ignored, so a read returns 0x00. When the window ends, the write-enable latch clears.
- R9: A read streams bytes from consecutive addresses and wraps from 0x3FF to 0x000.
- R10: An unrecognised opcode makes the block ignore all further bytes until `cs_n` next rises.
- R11: SCK may pause for any time between edges while selected, and the transfer continues correctly.
- R12: The write status command stores data bits 7:2 into status bits 7:2. It has the same gating and busy window as a memory write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low slave select |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for an external tri-state buffer on `so` |
| wp_n | input | 1 | Active-low write protect |

## Verification
Every serial input passes through a two-stage synchronizer and then an edge detector. A new SO bit therefore appears about four system clocks after the SCK falling edge. The bench holds each SCK level for eight system clocks and reads SO just before it raises SCK, so every bit is sampled several clocks after it settles. A commit begins about four clocks after select rises. The bench waits at least sixteen clocks after releasing select before it checks status. It then polls busy with repeated status reads until the bit clears, and checks memory contents and the latch only after that.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic [2:0] {
    ST_OP, ST_ADDR, ST_RDATA, ST_WDATA, ST_RSR, ST_WSR, ST_SKIP
  } smem_state_e;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;
endpackage

// File: rtl/smem_sync.sv
module smem_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/smem_array.sv
module smem_array #(
  parameter int   DEPTH   = 1024,
  parameter int   PAGE    = 16,
  parameter int   WR_CLKS = 400,
  localparam int  AW      = $clog2(DEPTH),
  localparam int  PW      = $clog2(PAGE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pb_clear,
  input  logic             pb_we,
  input  logic [PW-1:0]    pb_idx,
  input  logic [7:0]       pb_data,
  input  logic             commit,
  input  logic [AW-PW-1:0] commit_page,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             wr_done
);
  localparam int LAST = (WR_CLKS > PAGE) ? WR_CLKS : PAGE;
  localparam int CW   = $clog2(LAST + 1);

  logic [7:0]       mem  [DEPTH];
  logic [7:0]       pbuf [PAGE];
  logic [PAGE-1:0]  pval_q, pval_n;
  logic             busy_q, busy_n;
  logic             done_q, done_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [AW-PW-1:0] page_q;
  logic [PW-1:0]    cp_idx;
  logic             mem_we;
  logic             page_ld;

  assign cp_idx  = cnt_q[PW-1:0];
  assign page_ld = commit && !busy_q;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    pval_n = pval_q;
    done_n = 1'b0;
    mem_we = 1'b0;
    if (busy_q) begin
      cnt_n  = cnt_q + CW'(1);
      mem_we = (cnt_q < CW'(PAGE)) && pval_q[cp_idx];
      if (cnt_q == CW'(LAST - 1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        pval_n = '0;
      end
    end else if (commit) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else begin
      if (pb_clear) pval_n = '0;
      if (pb_we)    pval_n[pb_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      pval_q <= '0;
      page_q <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      cnt_q  <= cnt_n;
      pval_q <= pval_n;
      if (page_ld) page_q <= commit_page;
    end
  end

  always_ff @(posedge clk) begin
    if (pb_we && !busy_q) pbuf[pb_idx] <= pb_data;
    if (mem_we) mem[{page_q, cp_idx}] <= pbuf[cp_idx];
  end

  assign rd_data = mem[rd_addr];
  assign busy    = busy_q;
  assign wr_done = done_q;

  AST_COMMIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) commit |-> !busy_q); // R8
  AST_NO_FILL_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) pb_we |-> !busy_q); // R8
  AST_BUSY_LASTS: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_q) |=> busy_q); // R8
endmodule

// File: rtl/smem_ctrl.sv
module smem_ctrl
  import smem_pkg::*;
#(
  parameter int  DEPTH = 1024,
  parameter int  PAGE  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = $clog2(PAGE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             si,
  input  logic             wp_n,
  input  logic             busy,
  input  logic             wr_done,
  input  logic [7:0]       rd_byte,
  output logic             so,
  output logic             so_oe,
  output logic [AW-1:0]    rd_addr,
  output logic             pb_clear,
  output logic             pb_we,
  output logic [PW-1:0]    pb_idx,
  output logic [7:0]       pb_data,
  output logic             commit,
  output logic [AW-PW-1:0] commit_page
);
  smem_state_e   state_q, st_n;
  logic [3:0]    bcnt_q, bc_n;
  logic [7:0]    sh_q, sh_n;
  logic [AW-1:0] addr_q, ad_n;
  logic          rd_q, rd_n;
  logic          armed_q, arm_n;
  logic          wel_q, wel_n;
  logic          wpx_q, wpx_n;
  logic          got_q, got_n;
  logic          so_q, so_n;
  logic [7:0]    ob_q, ob_n;
  logic [5:0]    sfld_q, sf_n;
  logic [5:0]    pend_q, pd_n;
  logic          cs_d_q, sck_d_q;

  logic          cs_fall, cs_rise, sck_rise, sck_fall, active;
  logic [7:0]    shb, stat, obyte;
  logic          commit_ok;

  assign cs_fall  = cs_d_q && !cs_n;
  assign cs_rise  = !cs_d_q && cs_n;
  assign active   = !cs_n && armed_q;
  assign sck_rise = !sck_d_q && sck && active;
  assign sck_fall = sck_d_q && !sck && active;
  assign shb      = {sh_q[6:0], si};
  assign stat     = {sfld_q, wel_q, busy};
  assign obyte    = (state_q == ST_RSR) ? stat : rd_byte;
  assign commit_ok = armed_q && got_q && (bcnt_q == 4'd0) &&
                     ((state_q == ST_WDATA) || (state_q == ST_WSR)) &&
                     wel_q && wp_n && !wpx_q && !busy;

  assign pb_idx      = addr_q[PW-1:0];
  assign pb_data     = shb;
  assign commit_page = addr_q[AW-1:PW];
  assign rd_addr     = addr_q;
  assign so          = so_q;
  assign so_oe       = active;

  always_comb begin
    st_n   = state_q;
    bc_n   = bcnt_q;
    sh_n   = sh_q;
    ad_n   = addr_q;
    rd_n   = rd_q;
    arm_n  = armed_q;
    wel_n  = wel_q;
    wpx_n  = wpx_q;
    got_n  = got_q;
    so_n   = so_q;
    ob_n   = ob_q;
    sf_n   = sfld_q;
    pd_n   = pend_q;
    pb_clear = 1'b0;
    pb_we    = 1'b0;
    commit   = 1'b0;
    if (cs_fall) begin
      arm_n    = 1'b1;
      st_n     = ST_OP;
      bc_n     = 4'd0;
      pb_clear = 1'b1;
      wpx_n    = !wp_n;
      got_n    = 1'b0;
      so_n     = 1'b0;
    end else if (cs_rise) begin
      st_n = ST_OP;
      bc_n = 4'd0;
      if (commit_ok) begin
        commit = 1'b1;
        if (state_q == ST_WSR) sf_n = pend_q;
      end
    end else if (active) begin
      if (!wp_n) wpx_n = 1'b1;
      if (sck_rise) begin
        sh_n = shb;
        bc_n = bcnt_q + 4'd1;
        unique case (state_q)
          ST_OP: begin
            if (bcnt_q[2:0] == 3'd7) begin
              bc_n = 4'd0;
              st_n = ST_SKIP;
              if (!busy || shb == OPC_RDSR) begin
                unique case (shb)
                  OPC_WREN:  wel_n = 1'b1;
                  OPC_WRDI:  wel_n = 1'b0;
                  OPC_RDSR:  st_n  = ST_RSR;
                  OPC_WRSR:  st_n  = ST_WSR;
                  OPC_READ:  begin st_n = ST_ADDR; rd_n = 1'b1; end
                  OPC_WRITE: begin st_n = ST_ADDR; rd_n = 1'b0; end
                  default:   st_n  = ST_SKIP;
                endcase
              end
            end
          end
          ST_ADDR: begin
            ad_n = {addr_q[AW-2:0], si};
            if (bcnt_q == 4'd15) begin
              bc_n = 4'd0;
              st_n = rd_q ? ST_RDATA : ST_WDATA;
            end
          end
          ST_RDATA, ST_RSR: begin
            if (bcnt_q[2:0] == 3'd7) begin
              bc_n = 4'd0;
              if (state_q == ST_RDATA) ad_n = addr_q + AW'(1);
            end
          end
          ST_WDATA: begin
            if (bcnt_q[2:0] == 3'd7) begin
              bc_n  = 4'd0;
              pb_we = 1'b1;
              got_n = 1'b1;
              ad_n  = {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};
            end
          end
          ST_WSR: begin
            if (bcnt_q[2:0] == 3'd7) begin
              bc_n  = 4'd0;
              pd_n  = shb[7:2];
              got_n = 1'b1;
            end
          end
          default: bc_n = 4'd0;
        endcase
      end
      if (sck_fall && ((state_q == ST_RDATA) || (state_q == ST_RSR))) begin
        if (bcnt_q == 4'd0) begin
          so_n = obyte[7];
          ob_n = {obyte[6:0], 1'b0};
        end else begin
          so_n = ob_q[7];
          ob_n = {ob_q[6:0], 1'b0};
        end
      end
    end
    if (wr_done) wel_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OP;
      bcnt_q  <= 4'd0;
      sh_q    <= 8'd0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      armed_q <= 1'b0;
      wel_q   <= 1'b0;
      wpx_q   <= 1'b0;
      got_q   <= 1'b0;
      so_q    <= 1'b0;
      ob_q    <= 8'd0;
      sfld_q  <= 6'd0;
      pend_q  <= 6'd0;
      cs_d_q  <= 1'b0;
      sck_d_q <= 1'b0;
    end else begin
      state_q <= st_n;
      bcnt_q  <= bc_n;
      sh_q    <= sh_n;
      addr_q  <= ad_n;
      rd_q    <= rd_n;
      armed_q <= arm_n;
      wel_q   <= wel_n;
      wpx_q   <= wpx_n;
      got_q   <= got_n;
      so_q    <= so_n;
      ob_q    <= ob_n;
      sfld_q  <= sf_n;
      pend_q  <= pd_n;
      cs_d_q  <= cs_n;
      sck_d_q <= sck;
    end
  end

  AST_ARMED_BEFORE_CMD: assert property (@(posedge clk) disable iff (!rst_n) (state_q != ST_OP) |-> armed_q); // R3
  AST_SO_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) sck_rise |=> $stable(so_q)); // R1
  AST_WEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) wr_done |=> !wel_q); // R8
  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (!wp_n && !cs_n && armed_q) |=> !commit); // R6
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int DEPTH      = 1024,
  parameter int PAGE       = 16,
  parameter int WRITE_CLKS = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe,
  input  logic wp_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);

  logic [1:0]       rs_q;
  logic             rst_core_n;
  logic [3:0]       pin_s;
  logic             pb_clear, pb_we, commit, busy, wr_done;
  logic [PW-1:0]    pb_idx;
  logic [7:0]       pb_data, rd_byte;
  logic [AW-PW-1:0] commit_page;
  logic [AW-1:0]    rd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  smem_sync #(.W(4), .RST_VAL(4'b0001)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     ({cs_n, sck, si, wp_n}),
    .q     (pin_s)
  );

  smem_ctrl #(.DEPTH(DEPTH), .PAGE(PAGE)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .cs_n        (pin_s[3]),
    .sck         (pin_s[2]),
    .si          (pin_s[1]),
    .wp_n        (pin_s[0]),
    .busy        (busy),
    .wr_done     (wr_done),
    .rd_byte     (rd_byte),
    .so          (so),
    .so_oe       (so_oe),
    .rd_addr     (rd_addr),
    .pb_clear    (pb_clear),
    .pb_we       (pb_we),
    .pb_idx      (pb_idx),
    .pb_data     (pb_data),
    .commit      (commit),
    .commit_page (commit_page)
  );

  smem_array #(.DEPTH(DEPTH), .PAGE(PAGE), .WR_CLKS(WRITE_CLKS)) u_array (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .pb_clear    (pb_clear),
    .pb_we       (pb_we),
    .pb_idx      (pb_idx),
    .pb_data     (pb_data),
    .commit      (commit),
    .commit_page (commit_page),
    .rd_addr     (rd_addr),
    .rd_data     (rd_byte),
    .busy        (busy),
    .wr_done     (wr_done)
  );
endmodule

// File: tb/serial_mem_slave_test.sv
module serial_mem_slave_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic wp_n = 1'b1;
  wire  so, so_oe;

  always #2 clk = ~clk;

  serial_mem_slave #(.DEPTH(1024), .PAGE(16), .WRITE_CLKS(400)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_oe(so_oe), .wp_n(wp_n)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit pause_en = 1'b0;
  logic [7:0] mdl [1024];
  bit         mval [1024];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  function automatic logic [9:0] page_slot(logic [9:0] a, int i);
    return (a & 10'h3F0) | ((a + 10'(i)) & 10'h00F);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < n; i++) begin
      si = tx[7-i];
      tick(HALF);
      rx = {rx[6:0], so};
      sck = 1'b1;
      tick(HALF);
      if (pause_en && i == 3) tick(150);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    bits(tx, 8, rx);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic desel();
    tick(HALF);
    cs_n = 1'b1;
    tick(2*HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, st); desel();
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [9:0] a);
    logic [7:0] d;
    xfer(op, d);
    xfer({6'b0, a[9:8]}, d);
    xfer(a[7:0], d);
  endtask

  task automatic write_mem(input logic [9:0] a, input int n, input bit upd);
    logic [7:0] d;
    sel(); send_hdr(8'h02, a);
    for (int i = 0; i < n; i++) xfer(wbuf[i], d);
    desel();
    if (upd) begin
      for (int i = 0; i < n; i++) begin
        mdl[page_slot(a, i)]  = wbuf[i];
        mval[page_slot(a, i)] = 1'b1;
      end
    end
  endtask

  task automatic read_mem(input logic [9:0] a, input int n);
    logic [7:0] d;
    sel(); send_hdr(8'h03, a);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, d);
      rbuf[i] = d;
    end
    desel();
  endtask

  task automatic wait_ready();
    logic [7:0] st;
    st = 8'h01;
    for (int k = 0; k < 40; k++) begin
      rdsr(st);
      if (!st[0]) break;
    end
    chk("R8 busy clears", 32'(st[0]), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL WATCHDOG got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, d;
    logic [9:0] a;
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin mdl[i] = 8'h00; mval[i] = 1'b0; end

    tick(5);
    rst_n = 1'b1;
    tick(10);
    chk("R2 reset so_oe", 32'(so_oe), 32'd0);

    // R3: select held low since reset, so the command must be ignored
    xfer(8'h06, d);
    chk("R3 so_oe before arm", 32'(so_oe), 32'd0);
    cs_n = 1'b1;
    tick(2*HALF);
    rdsr(st);
    chk("R3 wel untouched", 32'(st), 32'h00);
    chk("R2 so_oe with cs high", 32'(so_oe), 32'd0);
    sel();
    chk("R2 so_oe when selected", 32'(so_oe), 32'd1);
    desel();

    cmd1(8'h06); rdsr(st);
    chk("R4 wren sets bit1", 32'(st), 32'h02);
    cmd1(8'h04); rdsr(st);
    chk("R4 wrdi clears bit1", 32'(st), 32'h00);

    // R1, R8: page write and read back
    cmd1(8'h06);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    write_mem(10'h105, 4, 1'b1);
    rdsr(st);
    chk("R8 busy and wel during window", 32'(st), 32'h03);
    wait_ready();
    rdsr(st);
    chk("R8 wel cleared after window", 32'(st), 32'h00);
    read_mem(10'h105, 4);
    for (int i = 0; i < 4; i++) chk("R1 read back", 32'(rbuf[i]), 32'(mdl[10'h105 + i]));

    // R8: read is ignored while busy
    cmd1(8'h06);
    wbuf[0] = 8'h5A;
    write_mem(10'h200, 1, 1'b1);
    read_mem(10'h105, 1);
    chk("R8 read ignored while busy", 32'(rbuf[0]), 32'h00);
    wait_ready();

    // R5: write without latch
    wbuf[0] = 8'h99;
    write_mem(10'h105, 1, 1'b0);
    rdsr(st);
    chk("R5 no busy without wel", 32'(st), 32'h00);
    read_mem(10'h105, 1);
    chk("R5 memory unchanged", 32'(rbuf[0]), 32'h11);

    // R6: protect pulse inside the transaction cancels the write
    cmd1(8'h06);
    sel(); send_hdr(8'h02, 10'h106); xfer(8'h77, d);
    wp_n = 1'b0; tick(HALF); wp_n = 1'b1;
    desel();
    rdsr(st);
    chk("R6 aborted write no busy, wel kept", 32'(st), 32'h02);
    read_mem(10'h106, 1);
    chk("R6 memory unchanged after abort", 32'(rbuf[0]), 32'h22);

    // R6: protect after commit start has no effect
    wbuf[0] = 8'hC3;
    write_mem(10'h107, 1, 1'b1);
    wp_n = 1'b0;
    wait_ready();
    wp_n = 1'b1;
    tick(HALF);
    read_mem(10'h107, 1);
    chk("R6 started write completes", 32'(rbuf[0]), 32'hC3);

    // R7: wrap within page
    cmd1(8'h06);
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
    write_mem(10'h13E, 4, 1'b1);
    wait_ready();
    read_mem(10'h13E, 2);
    chk("R7 page tail 0", 32'(rbuf[0]), 32'hA1);
    chk("R7 page tail 1", 32'(rbuf[1]), 32'hA2);
    read_mem(10'h130, 2);
    chk("R7 wrapped 0", 32'(rbuf[0]), 32'hA3);
    chk("R7 wrapped 1", 32'(rbuf[1]), 32'hA4);

    // R7: partial byte discards the write
    cmd1(8'h06);
    sel(); send_hdr(8'h02, 10'h130); xfer(8'hEE, d); bits(8'hF0, 3, d); desel();
    rdsr(st);
    chk("R7 partial byte no commit", 32'(st), 32'h02);
    read_mem(10'h130, 1);
    chk("R7 partial byte memory", 32'(rbuf[0]), 32'hA3);
    cmd1(8'h04);

    // R9: read wraps at the end of the array
    cmd1(8'h06);
    wbuf[0] = 8'h3E; wbuf[1] = 8'h3F;
    write_mem(10'h3FE, 2, 1'b1);
    wait_ready();
    cmd1(8'h06);
    wbuf[0] = 8'h00 ^ 8'h6C;
    write_mem(10'h000, 1, 1'b1);
    wait_ready();
    read_mem(10'h3FE, 3);
    chk("R9 byte 0x3FE", 32'(rbuf[0]), 32'h3E);
    chk("R9 byte 0x3FF", 32'(rbuf[1]), 32'h3F);
    chk("R9 wrap to 0x000", 32'(rbuf[2]), 32'h6C);

    // R10: unknown opcode swallows the rest of the transaction
    cmd1(8'h06);
    sel(); xfer(8'hFF, d); xfer(8'h04, d); xfer(8'h02, d); desel();
    rdsr(st);
    chk("R10 later bytes ignored", 32'(st), 32'h02);
    cmd1(8'h04);

    // R11: clock pause inside bytes
    pause_en = 1'b1;
    read_mem(10'h105, 3);
    pause_en = 1'b0;
    for (int i = 0; i < 3; i++) chk("R11 read with pause", 32'(rbuf[i]), 32'(mdl[10'h105 + i]));

    // R12: status write
    cmd1(8'h06);
    sel(); xfer(8'h01, d); xfer(8'hAB, d); desel();
    rdsr(st);
    chk("R12 status write busy", 32'(st), 32'hAB);
    wait_ready();
    rdsr(st);
    chk("R12 status field stored", 32'(st), 32'hA8);
    sel(); xfer(8'h01, d); xfer(8'h54, d); desel();
    rdsr(st);
    chk("R12 status write gated by wel", 32'(st), 32'hA8);

    // random page writes against the model (R1, R7)
    for (int it = 0; it < 8; it++) begin
      a = 10'($urandom % 1024);
      n = 1 + int'($urandom % 20);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      cmd1(8'h06);
      write_mem(a, n, 1'b1);
      wait_ready();
      read_mem(a & 10'h3F0, 16);
      for (int i = 0; i < 16; i++) begin
        if (mval[(a & 10'h3F0) + 10'(i)])
          chk("R7 random page", 32'(rbuf[i]), 32'(mdl[(a & 10'h3F0) + 10'(i)]));
      end
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule